// File: doc/BRIEF.md
# Nonvolatile Store and Recall Sequencer

This block sequences the nonvolatile transfers of a battery-free SRAM whose cells are shadowed by nonvolatile storage. When the supply comparator reports power good, the sequencer copies the nonvolatile image back into the SRAM and keeps the array locked for the recall time. A shared active-low store line, pulled up weakly and driven only by open-drain devices, lets any device on the board request a store. The sequencer qualifies a low level on that line, locks the array, and copies the SRAM into nonvolatile storage if the array was written since the last completed store. While it stores, it pulls the line low itself so that the other devices on the line see the busy state. Software can also ask for a store or a recall through two request strobes.

All delays are given in nanoseconds together with the clock period in picoseconds. They are converted to cycle counts when the block is built, and one shared down-counter times every step. After a store that came from the line or from software, the array stays locked until the synchronized line reads high again. If power good drops at any time, the sequencer aborts and starts over with a fresh recall on the next rise.

Top module: `nv_store_sequencer`

## Requirements
- R1: While reset is asserted or power good is low, `inhibit` is 1 and `busy`, `done` and `hsb_pull_en` are 0.
- R2: Power good is sampled high in the powered-off state. `busy` and `inhibit` are then 1 for exactly RECALL cycles, counted from the next clock edge. In the cycle after the last of these, `busy` and `inhibit` are 0 and `done` is 1 for exactly one cycle.
- R3: The synchronized store line must read low for at least PULSE consecutive cycles to count as a store request. A shorter low pulse starts no store, does not pull the line, and leaves the write flag unchanged.
- R4: The store line is sampled low on two consecutive clock edges while power good is high. `inhibit` is then 1 in the cycle after the second edge.
- R5: A qualified line request starts a store (`hsb_pull_en` and `busy` high for exactly STORE cycles, then a one-cycle `done`) only when the write flag is set. With the flag clear, `hsb_pull_en`, `busy` and `done` all stay 0.
- R6: After a store or a skipped store, `inhibit` stays 1 for as long as the line is held low. It returns to 0 in the third cycle after the line goes high.
- R7: Any `wr_stb` pulse sets the write flag. A completed store clears it. A recall and an aborted store leave it as it was.
- R8: A `sw_store_req` pulse in the idle state starts a store whether or not the flag is set. The store pulls the line low for STORE cycles and ends with `done`.
- R9: A `sw_recall_req` pulse in the idle state gives `busy` and `inhibit` for RECALL cycles, then `done`. It never pulls the line.
- R10: In the idle state a line request wins over a software store, and a software store wins over a software recall. Software requests that arrive while busy are ignored.
- R11: When power good goes low, `inhibit` is 1 and `busy` and `hsb_pull_en` are 0 from the next cycle on. An open store is abandoned. The next rise of power good starts a new recall.
- R12: `hsb_pull_en` is 1 only while `busy` and `inhibit` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock with period CLK_PERIOD_PS |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_good | input | 1 | Supply above switch threshold, synchronous to clk |
| hsb_in | input | 1 | Sampled level of the shared active-low store line |
| wr_stb | input | 1 | One-cycle strobe per SRAM write |
| sw_store_req | input | 1 | Software store request strobe |
| sw_recall_req | input | 1 | Software recall request strobe |
| hsb_pull_en | output | 1 | Enables the open-drain pull-down on the store line |
| inhibit | output | 1 | Blocks SRAM accesses |
| busy | output | 1 | A store or recall is in progress |
| done | output | 1 | One-cycle pulse when a store or recall completes |

## Verification
The bound checker watches these properties on every cycle: the pull-down is never enabled outside a busy, inhibited state; a low line always locks the array within two sampled edges; a store never starts with a clean write flag unless software asked for it; `done` is a single-cycle pulse that follows a busy cycle; and a power drop shuts everything down on the next cycle. Some behaviour only the bench scenarios can show. This includes the exact recall and store lengths, where a pulse stops being too short, the release timing after the line goes high, and whether the write flag survives recalls, short pulses and aborted stores, seen through later stores that do or do not happen.

// File: rtl/nvseq_pkg.sv
// Shared types and elaboration-time helpers for the nonvolatile sequencer.
// Assumes: delays are given in nanoseconds and the clock period in picoseconds.
package nvseq_pkg;

    // Controller states; IDLE is the only state in which the array is usable.
    typedef enum logic [2:0] {
        NS_OFF,
        NS_RECALL,
        NS_IDLE,
        NS_QUAL,
        NS_STORE,
        NS_HOLD
    } nv_state_e;

    // Converts a delay to a clock-cycle count, rounding up, with a minimum of one.
    function automatic int unsigned ns_to_cycles(input longint unsigned ns,
                                                 input longint unsigned period_ps);
        longint unsigned c;
        c = (ns * 64'd1000 + period_ps - 64'd1) / period_ps;
        if (c == 64'd0) begin
            c = 64'd1;
        end
        return 32'(c);
    endfunction

    // Largest of three counts; sizes the shared timer.
    function automatic int unsigned max3(input int unsigned a,
                                         input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/nvseq_pin_sync.sv
// Synchronizes the asynchronous shared store line into the clock domain.
// Assumes: STAGES >= 2; the line idles high (weak pull-up), so the flops reset to 1.
module nvseq_pin_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic pin_low
);

    logic [STAGES-1:0] sh;

    // Shift the raw line level through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh <= '1;
        end else begin
            sh <= {sh[STAGES-2:0], pin};
        end
    end

    assign pin_low = ~sh[STAGES-1];

endmodule

// File: rtl/nvseq_timer.sv
// Single shared down-counter that times every step of the sequencer.
// Assumes: a load value N makes 'last' rise in the N-th cycle after the load edge.
module nvseq_timer #(
    parameter int unsigned TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          last
);

    logic [TW-1:0] cnt;

    // Load on request, otherwise count down to zero and stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - TW'(1);
        end
    end

    assign last = (cnt == TW'(1));

endmodule

// File: rtl/nvseq_dirty.sv
// Tracks whether the SRAM was written since the last completed store.
// Assumes: a write and a store completion in the same cycle leave the flag set.
module nvseq_dirty (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_stb,
    input  logic clear,
    output logic dirty
);

    // Set on any write; clear only when a store has finished.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dirty <= 1'b0;
        end else if (wr_stb) begin
            dirty <= 1'b1;
        end else if (clear) begin
            dirty <= 1'b0;
        end
    end

endmodule

// File: rtl/nvseq_ctrl.sv
// Sequencing state machine: power-up recall, line-qualified and software stores,
// software recall, and the locked wait for the store line to be released.
// Assumes: pwr_good is synchronous; pin_low is already synchronized; the timer
// raises tmr_last in the N-th cycle of a state entered with load value N.
module nvseq_ctrl #(
    parameter int unsigned TW         = 8,
    parameter int unsigned RECALL_CYC = 100,
    parameter int unsigned STORE_CYC  = 200,
    parameter int unsigned QUAL_CYC   = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pwr_good,
    input  logic          pin_low,
    input  logic          dirty,
    input  logic          sw_store_req,
    input  logic          sw_recall_req,
    input  logic          tmr_last,
    output logic          tmr_load,
    output logic [TW-1:0] tmr_val,
    output logic          store_done,
    output logic          hsb_pull_en,
    output logic          inhibit,
    output logic          busy,
    output logic          done
);

    import nvseq_pkg::*;

    localparam logic [TW-1:0] RECALL_LD = TW'(RECALL_CYC);
    localparam logic [TW-1:0] STORE_LD  = TW'(STORE_CYC);
    localparam logic [TW-1:0] QUAL_LD   = TW'(QUAL_CYC);

    nv_state_e st;
    nv_state_e st_nxt;
    logic      done_nxt;
    logic      done_q;

    // Next-state, timer-load and completion decode.
    always_comb begin
        st_nxt     = st;
        tmr_load   = 1'b0;
        tmr_val    = '0;
        store_done = 1'b0;
        done_nxt   = 1'b0;
        if (!pwr_good) begin
            st_nxt = NS_OFF;
        end else begin
            case (st)
                NS_OFF: begin
                    st_nxt   = NS_RECALL;
                    tmr_load = 1'b1;
                    tmr_val  = RECALL_LD;
                end
                NS_RECALL: begin
                    if (tmr_last) begin
                        st_nxt   = NS_IDLE;
                        done_nxt = 1'b1;
                    end
                end
                NS_IDLE: begin
                    if (pin_low) begin
                        st_nxt   = NS_QUAL;
                        tmr_load = 1'b1;
                        tmr_val  = QUAL_LD;
                    end else if (sw_store_req) begin
                        st_nxt   = NS_STORE;
                        tmr_load = 1'b1;
                        tmr_val  = STORE_LD;
                    end else if (sw_recall_req) begin
                        st_nxt   = NS_RECALL;
                        tmr_load = 1'b1;
                        tmr_val  = RECALL_LD;
                    end
                end
                NS_QUAL: begin
                    if (!pin_low) begin
                        st_nxt = NS_IDLE;
                    end else if (tmr_last) begin
                        if (dirty) begin
                            st_nxt   = NS_STORE;
                            tmr_load = 1'b1;
                            tmr_val  = STORE_LD;
                        end else begin
                            st_nxt = NS_HOLD;
                        end
                    end
                end
                NS_STORE: begin
                    if (tmr_last) begin
                        st_nxt     = NS_HOLD;
                        store_done = 1'b1;
                        done_nxt   = 1'b1;
                    end
                end
                NS_HOLD: begin
                    if (!pin_low) begin
                        st_nxt = NS_IDLE;
                    end
                end
                default: st_nxt = NS_OFF;
            endcase
        end
    end

    // State and completion-pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= NS_OFF;
            done_q <= 1'b0;
        end else begin
            st     <= st_nxt;
            done_q <= done_nxt;
        end
    end

    assign hsb_pull_en = (st == NS_STORE);
    assign busy        = (st == NS_STORE) || (st == NS_RECALL);
    assign inhibit     = (st != NS_IDLE) || pin_low;
    assign done        = done_q;

endmodule

// File: rtl/nv_store_sequencer.sv
// Top level: converts the delay parameters to cycle counts and connects the
// synchronizer, write-flag tracker, shared timer and sequencing state machine.
// Assumes: pwr_good comes from a comparator already synchronized to clk.
module nv_store_sequencer #(
    parameter int unsigned CLK_PERIOD_PS = 4000,
    parameter int unsigned RECALL_NS     = 650000,
    parameter int unsigned STORE_NS      = 10000000,
    parameter int unsigned PULSE_NS      = 250,
    parameter int unsigned SYNC_STAGES   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_good,
    input  logic hsb_in,
    input  logic wr_stb,
    input  logic sw_store_req,
    input  logic sw_recall_req,
    output logic hsb_pull_en,
    output logic inhibit,
    output logic busy,
    output logic done
);

    import nvseq_pkg::*;

    localparam int unsigned RECALL_CYC = ns_to_cycles(64'(RECALL_NS), 64'(CLK_PERIOD_PS));
    localparam int unsigned STORE_CYC  = ns_to_cycles(64'(STORE_NS), 64'(CLK_PERIOD_PS));
    localparam int unsigned PULSE_CYC  = ns_to_cycles(64'(PULSE_NS), 64'(CLK_PERIOD_PS));
    localparam int unsigned QUAL_CYC   = (PULSE_CYC > 1) ? PULSE_CYC - 1 : 1;
    localparam int unsigned MAX_CYC    = max3(RECALL_CYC, STORE_CYC, QUAL_CYC);
    localparam int unsigned TW         = $clog2(MAX_CYC + 1);

    logic          pin_low;
    logic          wr_dirty;
    logic          store_done;
    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_last;

    nvseq_pin_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin     (hsb_in),
        .pin_low (pin_low)
    );

    nvseq_dirty u_dirty (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_stb (wr_stb),
        .clear  (store_done),
        .dirty  (wr_dirty)
    );

    nvseq_timer #(
        .TW (TW)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .last     (tmr_last)
    );

    nvseq_ctrl #(
        .TW         (TW),
        .RECALL_CYC (RECALL_CYC),
        .STORE_CYC  (STORE_CYC),
        .QUAL_CYC   (QUAL_CYC)
    ) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .pwr_good      (pwr_good),
        .pin_low       (pin_low),
        .dirty         (wr_dirty),
        .sw_store_req  (sw_store_req),
        .sw_recall_req (sw_recall_req),
        .tmr_last      (tmr_last),
        .tmr_load      (tmr_load),
        .tmr_val       (tmr_val),
        .store_done    (store_done),
        .hsb_pull_en   (hsb_pull_en),
        .inhibit       (inhibit),
        .busy          (busy),
        .done          (done)
    );

endmodule

// File: rtl/nv_store_sequencer_chk.sv
// Protocol checker for the sequencer, bound to every instance of the top module.
// Assumes: the default two-stage synchronizer on the store line.
module nv_store_sequencer_chk (
    input logic clk,
    input logic rst_n,
    input logic pwr_good,
    input logic hsb_in,
    input logic sw_store_req,
    input logic hsb_pull_en,
    input logic inhibit,
    input logic busy,
    input logic done,
    input logic dirty
);

    logic [1:0] age;

    // Counts edges since reset so that history-based checks start when valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            age <= 2'd0;
        end else if (age != 2'd3) begin
            age <= age + 2'd1;
        end
    end

    p_pull_needs_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
        hsb_pull_en |-> (busy && inhibit));

    p_inhibit_on_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd3 && !$past(hsb_in) && !$past(hsb_in, 2)) |-> inhibit);

    p_clean_store_skipped_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd3 && $rose(hsb_pull_en)) |-> ($past(dirty) || $past(sw_store_req)));

    p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_after_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (age != 2'd0 && done) |-> $past(busy));

    p_powerdown_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_good |=> (inhibit && !busy && !hsb_pull_en));

endmodule

bind nv_store_sequencer nv_store_sequencer_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pwr_good     (pwr_good),
    .hsb_in       (hsb_in),
    .sw_store_req (sw_store_req),
    .hsb_pull_en  (hsb_pull_en),
    .inhibit      (inhibit),
    .busy         (busy),
    .done         (done),
    .dirty        (wr_dirty)
);

// File: tb/nv_store_sequencer_test.sv
`timescale 1ns/1ps
module nv_store_sequencer_test;

    localparam int RECALL_CYC = 100;   // 400 ns at 4 ns
    localparam int STORE_CYC  = 200;   // 800 ns at 4 ns
    localparam int PULSE_CYC  = 10;    // 40 ns at 4 ns

    // Row: {write first, low length in cycles, store expected}
    localparam logic [9:0] VECS [0:7] = '{
        {1'b1, 8'd10,  1'b1},
        {1'b0, 8'd10,  1'b0},
        {1'b1, 8'd9,   1'b0},
        {1'b0, 8'd12,  1'b1},
        {1'b0, 8'd30,  1'b0},
        {1'b1, 8'd1,   1'b0},
        {1'b0, 8'd10,  1'b1},
        {1'b1, 8'd250, 1'b1}
    };

    logic clk = 1'b0;
    logic rst_n, pwr_good, ext_low, wr_stb, sw_store_req, sw_recall_req;
    logic hsb_pull_en, inhibit, busy, done;
    logic hsb_in;

    int n_checks = 0;
    int n_fail = 0;
    int pull_cnt = 0, busy_cnt = 0, done_cnt = 0, bad_pull = 0;
    int b_pull, b_busy, b_done;
    bit finished = 0;

    always #2 clk = ~clk;

    assign hsb_in = ~(ext_low | hsb_pull_en);

    nv_store_sequencer #(
        .CLK_PERIOD_PS (4000),
        .RECALL_NS     (400),
        .STORE_NS      (800),
        .PULSE_NS      (40),
        .SYNC_STAGES   (2)
    ) uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .pwr_good      (pwr_good),
        .hsb_in        (hsb_in),
        .wr_stb        (wr_stb),
        .sw_store_req  (sw_store_req),
        .sw_recall_req (sw_recall_req),
        .hsb_pull_en   (hsb_pull_en),
        .inhibit       (inhibit),
        .busy          (busy),
        .done          (done)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (hsb_pull_en) pull_cnt <= pull_cnt + 1;
            if (busy) busy_cnt <= busy_cnt + 1;
            if (done) done_cnt <= done_cnt + 1;
            if (hsb_pull_en && !(busy && inhibit)) bad_pull <= bad_pull + 1;
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #0.5;
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic snap();
        b_pull = pull_cnt;
        b_busy = busy_cnt;
        b_done = done_cnt;
    endtask

    task automatic wait_idle();
        step(4);
        for (int i = 0; i < 5000; i++) begin
            if (!inhibit) break;
            step(1);
        end
        step(2);
    endtask

    task automatic pulse_write();
        wr_stb = 1'b1;
        step(1);
        wr_stb = 1'b0;
    endtask

    task automatic run_hw(input bit wr, input int len, input bit exp, input string tag);
        if (wr) pulse_write();
        snap();
        ext_low = 1'b1;
        step(len);
        ext_low = 1'b0;
        wait_idle();
        check(pull_cnt - b_pull == (exp ? STORE_CYC : 0), tag, pull_cnt - b_pull, exp ? STORE_CYC : 0);
        check(done_cnt - b_done == (exp ? 1 : 0), tag, done_cnt - b_done, exp ? 1 : 0);
        check(inhibit == 1'b0, tag, int'(inhibit), 0);
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; pwr_good = 1'b0; ext_low = 1'b0; wr_stb = 1'b0;
        sw_store_req = 1'b0; sw_recall_req = 1'b0;
        step(3);
        // R1: reset state
        check(inhibit == 1'b1, "R1", int'(inhibit), 1);
        check(busy == 1'b0, "R1", int'(busy), 0);
        check(hsb_pull_en == 1'b0, "R1", int'(hsb_pull_en), 0);
        check(done == 1'b0, "R1", int'(done), 0);
        rst_n = 1'b1;
        step(3);
        check(inhibit == 1'b1 && busy == 1'b0, "R1", int'(busy), 0);

        // R2: power-up recall length and done pulse
        pwr_good = 1'b1;
        step(1);
        check(busy == 1'b1 && inhibit == 1'b1, "R2", int'(busy), 1);
        step(RECALL_CYC - 1);
        check(busy == 1'b1, "R2", int'(busy), 1);
        step(1);
        check(busy == 1'b0 && inhibit == 1'b0, "R2", int'(inhibit), 0);
        check(done == 1'b1, "R2", int'(done), 1);
        step(1);
        check(done == 1'b0, "R2", int'(done), 0);

        // R4: inhibit two edges after the line falls; R3: short pulse then ignored
        snap();
        ext_low = 1'b1;
        step(2);
        check(inhibit == 1'b1, "R4", int'(inhibit), 1);
        step(3);
        ext_low = 1'b0;
        step(3);
        check(inhibit == 1'b0, "R3", int'(inhibit), 0);
        check(pull_cnt == b_pull, "R3", pull_cnt - b_pull, 0);

        // Table: line requests with and without writes (R3, R5, R7)
        for (int i = 0; i < 8; i++) begin
            run_hw(VECS[i][9], int'(VECS[i][8:1]), VECS[i][0], "R3/R5/R7");
        end

        // R6: skipped store holds inhibit until release, then frees it in 3 cycles
        snap();
        ext_low = 1'b1;
        step(30);
        check(inhibit == 1'b1 && pull_cnt == b_pull, "R6", int'(inhibit), 1);
        step(50);
        check(inhibit == 1'b1, "R6", int'(inhibit), 1);
        ext_low = 1'b0;
        step(2);
        check(inhibit == 1'b1, "R6", int'(inhibit), 1);
        step(1);
        check(inhibit == 1'b0, "R6", int'(inhibit), 0);

        // R8: software store with a clean flag still stores
        snap();
        sw_store_req = 1'b1;
        step(1);
        sw_store_req = 1'b0;
        wait_idle();
        check(pull_cnt - b_pull == STORE_CYC, "R8", pull_cnt - b_pull, STORE_CYC);
        check(done_cnt - b_done == 1, "R8", done_cnt - b_done, 1);

        // R9: software recall; R7: the recall keeps the write flag
        pulse_write();
        snap();
        sw_recall_req = 1'b1;
        step(1);
        sw_recall_req = 1'b0;
        wait_idle();
        check(busy_cnt - b_busy == RECALL_CYC, "R9", busy_cnt - b_busy, RECALL_CYC);
        check(pull_cnt == b_pull && done_cnt - b_done == 1, "R9", pull_cnt - b_pull, 0);
        run_hw(1'b0, 15, 1'b1, "R7");

        // R10: software store wins over software recall
        snap();
        sw_store_req = 1'b1; sw_recall_req = 1'b1;
        step(1);
        sw_store_req = 1'b0; sw_recall_req = 1'b0;
        wait_idle();
        check(pull_cnt - b_pull == STORE_CYC, "R10", pull_cnt - b_pull, STORE_CYC);
        check(busy_cnt - b_busy == STORE_CYC, "R10", busy_cnt - b_busy, STORE_CYC);

        // R10: line request wins over a simultaneous software store (flag clean -> skip)
        snap();
        ext_low = 1'b1;
        step(2);
        sw_store_req = 1'b1;
        step(1);
        sw_store_req = 1'b0;
        step(12);
        ext_low = 1'b0;
        wait_idle();
        check(pull_cnt == b_pull, "R10", pull_cnt - b_pull, 0);

        // R10: software store during a recall is ignored
        snap();
        sw_recall_req = 1'b1;
        step(1);
        sw_recall_req = 1'b0;
        step(5);
        sw_store_req = 1'b1;
        step(1);
        sw_store_req = 1'b0;
        wait_idle();
        check(pull_cnt == b_pull && busy_cnt - b_busy == RECALL_CYC, "R10", busy_cnt - b_busy, RECALL_CYC);

        // R11: power loss in the middle of a store
        pulse_write();
        sw_store_req = 1'b1;
        step(1);
        sw_store_req = 1'b0;
        step(20);
        pwr_good = 1'b0;
        step(1);
        check(inhibit == 1'b1 && busy == 1'b0 && hsb_pull_en == 1'b0, "R11", int'(busy), 0);
        step(3);
        snap();
        pwr_good = 1'b1;
        wait_idle();
        check(busy_cnt - b_busy == RECALL_CYC, "R11", busy_cnt - b_busy, RECALL_CYC);
        check(done_cnt - b_done == 1 && pull_cnt == b_pull, "R11", done_cnt - b_done, 1);
        run_hw(1'b0, 12, 1'b1, "R7/R11");

        // R12: pull-down never seen outside busy and inhibit
        check(bad_pull == 0, "R12", bad_pull, 0);

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule